// File: doc/BRIEF.md
# Loopback Routing Header Rewriter

This block sits in the receive path for bus cells. Cells arrive as a stream of words, and the first word of each cell carries the routing header. When that header carries the loopback type code, the block overwrites the top twelve bits of the header word with a value that the local processor has programmed. The rewritten cell can then be sent out again to another destination. Every other cell, every word after the header, and every header bit below the top twelve leave the block unchanged. All words take the same fixed pipeline latency.

A loopback cell is pending from the cycle after its header is accepted until the retransmit side reports completion on `tx_done`. The processor should only change the programmed value while no loopback cell is pending. A write during that window is not lost. It is held in a shadow register and takes effect when the pending cell completes. A sticky flag records that the collision happened.

Top module: `lbk_hdr_rewriter`

## Requirements
- R1: After reset, `out_valid`, `lb_pending` and `collision_err` are 0, and `lb_value` equals the reset value parameter (default 12'h000).
- R2: A word whose first-word type field (bits [19:16], default width 4) is not the loopback code (default 4'hA) appears unchanged on `out_data`, with `out_valid` and `out_sop` matching, exactly 2 clock cycles after it is accepted (PIPE_STAGES default 2).
- R3: On an accepted first word (`in_valid` and `in_sop` high) whose type field equals the loopback code, bits [31:20] of the output word equal the active `lb_value` at acceptance. Bits [19:0] are unchanged, and the latency is the same as in R2.
- R4: Words after the first word of a loopback cell are forwarded unchanged.
- R5: The type field is decoded only on an accepted first word. A loopback code seen in a later word, or while `in_valid` is low, causes no rewrite and does not set `lb_pending`.
- R6: `lb_pending` rises the cycle after a loopback header is accepted. It falls the cycle after `tx_done` is high while pending, unless a new loopback header is accepted in that same cycle.
- R7: A `cfg_we` write while not pending, and not coinciding with a loopback header, updates `lb_value` the next cycle. The next loopback cell uses the new value.
- R8: A write while pending, or in the cycle a loopback header is accepted, leaves `lb_value` unchanged. It sets `collision_err` the next cycle and is applied the cycle after the releasing `tx_done`.
- R9: When several writes are deferred, the last one is the value applied on release.
- R10: `collision_err` stays set until reset. A write while idle does not set it.
- R11: A write in the same cycle as a releasing `tx_done` is applied the next cycle and counts as a collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_sop | input | 1 | Input word is the first (header) word of a cell |
| in_data | input | 32 | Input cell word |
| cfg_we | input | 1 | Processor write strobe for the loopback value |
| cfg_value | input | 12 | Value written by the processor |
| tx_done | input | 1 | Pending loopback cell has been retransmitted |
| out_valid | output | 1 | Output word valid |
| out_sop | output | 1 | Output word is a header word |
| out_data | output | 32 | Output cell word, possibly rewritten |
| lb_pending | output | 1 | A loopback cell is between acceptance and retransmission |
| lb_value | output | 12 | Active loopback header value |
| collision_err | output | 1 | Sticky: a write arrived while a loopback was pending |

## Verification
Stream results are due two cycles after the input word is presented. The control outputs `lb_pending`, `lb_value` and `collision_err` are due one cycle after the stimulus. The bench drives inputs on falling edges. At each following falling edge, before it drives new inputs, it compares the control outputs with a model updated at the previous step. It keeps a two-deep queue of expected stream words, so each output word is compared at the edge where it is due. A sweep over all sixteen type codes and several programmed values covers the stream path. Directed sequences cover the write timing corners.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
   localparam int unsigned LBK_FIELD_W = 12;
   typedef logic [LBK_FIELD_W-1:0] lbk_field_t;
endpackage

// File: rtl/lbk_type_detect.sv
module lbk_type_detect #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned TYPE_LSB  = 16,
   parameter int unsigned TYPE_W    = 4,
   parameter int unsigned LOOP_CODE = 10
) (
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic [DATA_W-1:0] in_data,
   output logic              loop_hdr
);
   localparam logic [TYPE_W-1:0] CODE = TYPE_W'(LOOP_CODE);

   generate
      if (TYPE_W == 0 || TYPE_LSB + TYPE_W > DATA_W) begin : g_bad_field
         $error("lbk_type_detect: type field outside the word");
      end
      if (LOOP_CODE >= (1 << TYPE_W)) begin : g_bad_code
         $error("lbk_type_detect: loopback code does not fit the type field");
      end
   endgenerate

   logic [TYPE_W-1:0] type_field;
   assign type_field = in_data[TYPE_LSB +: TYPE_W];
   assign loop_hdr   = in_valid & in_sop & (type_field == CODE);
endmodule

// File: rtl/lbk_cfg_ctrl.sv
module lbk_cfg_ctrl
   import lbk_pkg::*;
#(
   parameter lbk_field_t RESET_VALUE = '0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  lbk_field_t cfg_value,
   input  logic       loop_hdr,
   input  logic       tx_done,
   output lbk_field_t active,
   output logic       pending,
   output logic       collision_err
);
   lbk_field_t shadow_q;
   logic       shadow_vld_q;
   logic       busy;
   logic       release_now;

   assign busy        = pending | loop_hdr;
   assign release_now = tx_done & pending & ~loop_hdr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active        <= RESET_VALUE;
         shadow_q      <= '0;
         shadow_vld_q  <= 1'b0;
         pending       <= 1'b0;
         collision_err <= 1'b0;
      end else begin
         if (cfg_we && busy) begin
            collision_err <= 1'b1;
         end
         if (release_now) begin
            if (cfg_we) begin
               active <= cfg_value;
            end else if (shadow_vld_q) begin
               active <= shadow_q;
            end
            shadow_vld_q <= 1'b0;
         end else if (cfg_we && !busy) begin
            active <= cfg_value;
         end else if (cfg_we) begin
            shadow_q     <= cfg_value;
            shadow_vld_q <= 1'b1;
         end
         if (loop_hdr) begin
            pending <= 1'b1;
         end else if (tx_done) begin
            pending <= 1'b0;
         end
      end
   end

   assert_pend_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      loop_hdr |=> pending);
   assert_pend_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && tx_done && !loop_hdr) |=> !pending);
   assert_value_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !tx_done) |=> $stable(active));
   assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (pending || loop_hdr)) |=> collision_err);
   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      collision_err |=> collision_err);
   assert_idle_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !pending && !loop_hdr) |=> (active == $past(cfg_value)));
endmodule

// File: rtl/lbk_hdr_pipe.sv
module lbk_hdr_pipe #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned FIELD_W     = 12,
   parameter int unsigned PIPE_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic               in_sop,
   input  logic [DATA_W-1:0]  in_data,
   input  logic               rewrite,
   input  logic [FIELD_W-1:0] new_field,
   output logic               out_valid,
   output logic               out_sop,
   output logic [DATA_W-1:0]  out_data
);
   localparam int unsigned KEEP_W = DATA_W - FIELD_W;

   generate
      if (PIPE_STAGES < 1 || PIPE_STAGES > 8) begin : g_bad_depth
         $error("lbk_hdr_pipe: PIPE_STAGES must be 1..8");
      end
      if (FIELD_W == 0 || FIELD_W >= DATA_W) begin : g_bad_width
         $error("lbk_hdr_pipe: field must be narrower than the word");
      end
   endgenerate

   logic [PIPE_STAGES-1:0] vld_q;
   logic [PIPE_STAGES-1:0] sop_q;
   logic [DATA_W-1:0]      dat_q [PIPE_STAGES];
   logic [DATA_W-1:0]      first_word;

   assign first_word = rewrite ? {new_field, in_data[KEEP_W-1:0]} : in_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q[0] <= 1'b0;
         sop_q[0] <= 1'b0;
         dat_q[0] <= '0;
      end else begin
         vld_q[0] <= in_valid;
         sop_q[0] <= in_valid & in_sop;
         dat_q[0] <= first_word;
      end
   end

   generate
      for (genvar i = 1; i < PIPE_STAGES; i++) begin : g_delay
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q[i] <= 1'b0;
               sop_q[i] <= 1'b0;
               dat_q[i] <= '0;
            end else begin
               vld_q[i] <= vld_q[i-1];
               sop_q[i] <= sop_q[i-1];
               dat_q[i] <= dat_q[i-1];
            end
         end
      end
   endgenerate

   assign out_valid = vld_q[PIPE_STAGES-1];
   assign out_sop   = sop_q[PIPE_STAGES-1];
   assign out_data  = dat_q[PIPE_STAGES-1];

   assert_low_bits_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && rewrite) |=> (dat_q[0][KEEP_W-1:0] == $past(in_data[KEEP_W-1:0])));
   assert_plain_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !rewrite) |=> (dat_q[0] == $past(in_data)));
endmodule

// File: rtl/lbk_hdr_rewriter.sv
module lbk_hdr_rewriter
   import lbk_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned TYPE_LSB    = 16,
   parameter int unsigned TYPE_W      = 4,
   parameter int unsigned LOOP_CODE   = 10,
   parameter int unsigned PIPE_STAGES = 2,
   parameter lbk_field_t  RESET_VALUE = '0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic                   in_sop,
   input  logic [DATA_W-1:0]      in_data,
   input  logic                   cfg_we,
   input  logic [LBK_FIELD_W-1:0] cfg_value,
   input  logic                   tx_done,
   output logic                   out_valid,
   output logic                   out_sop,
   output logic [DATA_W-1:0]      out_data,
   output logic                   lb_pending,
   output logic [LBK_FIELD_W-1:0] lb_value,
   output logic                   collision_err
);
   localparam int unsigned KEEP_W = DATA_W - LBK_FIELD_W;

   generate
      if (TYPE_LSB + TYPE_W > KEEP_W) begin : g_type_overlap
         $error("lbk_hdr_rewriter: type field would be overwritten by the rewrite");
      end
   endgenerate

   logic       loop_hdr;
   lbk_field_t active;

   lbk_type_detect #(
      .DATA_W   (DATA_W),
      .TYPE_LSB (TYPE_LSB),
      .TYPE_W   (TYPE_W),
      .LOOP_CODE(LOOP_CODE)
   ) u_detect (
      .in_valid(in_valid),
      .in_sop  (in_sop),
      .in_data (in_data),
      .loop_hdr(loop_hdr)
   );

   lbk_cfg_ctrl #(
      .RESET_VALUE(RESET_VALUE)
   ) u_cfg (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_value    (cfg_value),
      .loop_hdr     (loop_hdr),
      .tx_done      (tx_done),
      .active       (active),
      .pending      (lb_pending),
      .collision_err(collision_err)
   );

   lbk_hdr_pipe #(
      .DATA_W     (DATA_W),
      .FIELD_W    (LBK_FIELD_W),
      .PIPE_STAGES(PIPE_STAGES)
   ) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_sop   (in_sop),
      .in_data  (in_data),
      .rewrite  (loop_hdr),
      .new_field(active),
      .out_valid(out_valid),
      .out_sop  (out_sop),
      .out_data (out_data)
   );

   assign lb_value = active;

   assert_sop_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_sop |-> out_valid);
endmodule

// File: tb/lbk_hdr_rewriter_tb.sv
module lbk_hdr_rewriter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_sop = 1'b0;
   logic [31:0] in_data = '0;
   logic        cfg_we = 1'b0;
   logic [11:0] cfg_value = '0;
   logic        tx_done = 1'b0;
   logic        out_valid, out_sop, lb_pending, collision_err;
   logic [31:0] out_data;
   logic [11:0] lb_value;

   int total = 0;
   int bad = 0;

   // model state
   logic        m_pend = 1'b0, m_err = 1'b0, m_shv = 1'b0;
   logic [11:0] m_act = '0, m_sh = '0;
   logic        e1v = 1'b0, e2v = 1'b0, e1s = 1'b0, e2s = 1'b0;
   logic [31:0] e1d = '0, e2d = '0;
   string       e1t = "R1", e2t = "R1";

   always #4 clk = ~clk;

   lbk_hdr_rewriter u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_data(in_data), .cfg_we(cfg_we), .cfg_value(cfg_value), .tx_done(tx_done),
      .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data),
      .lb_pending(lb_pending), .lb_value(lb_value), .collision_err(collision_err)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic iv, input logic isop, input logic [31:0] d,
                       input logic we, input logic [11:0] wv, input logic txd);
      logic        loop, busy, rel;
      @(negedge clk);
      check({e2t, " valid"}, {31'd0, out_valid}, {31'd0, e2v});
      if (e2v) begin
         check({e2t, " sop"}, {31'd0, out_sop}, {31'd0, e2s});
         check({e2t, " data"}, out_data, e2d);
      end
      check("R6 pending", {31'd0, lb_pending}, {31'd0, m_pend});
      check("R7 value", {20'd0, lb_value}, {20'd0, m_act});
      check("R10 err", {31'd0, collision_err}, {31'd0, m_err});
      in_valid = iv; in_sop = isop; in_data = d;
      cfg_we = we; cfg_value = wv; tx_done = txd;
      loop = iv && isop && (d[19:16] == 4'hA);
      busy = m_pend || loop;
      rel  = txd && m_pend && !loop;
      e2v = e1v; e2s = e1s; e2d = e1d; e2t = e1t;
      e1v = iv; e1s = iv && isop;
      e1d = loop ? {m_act, d[19:0]} : d;
      e1t = loop ? "R3" : ((iv && isop) ? "R2" : ((d[19:16] == 4'hA) ? "R5" : "R4"));
      if (we && busy) m_err = 1'b1;
      if (rel) begin
         if (we) m_act = wv;
         else if (m_shv) m_act = m_sh;
         m_shv = 1'b0;
      end else if (we && !busy) begin
         m_act = wv;
      end else if (we) begin
         m_sh = wv; m_shv = 1'b1;
      end
      if (loop) m_pend = 1'b1;
      else if (txd) m_pend = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(1'b0, 1'b0, 32'h0, 1'b0, 12'h0, 1'b0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 out_valid", {31'd0, out_valid}, 32'd0);
      check("R1 pending", {31'd0, lb_pending}, 32'd0);
      check("R1 err", {31'd0, collision_err}, 32'd0);
      check("R1 value", {20'd0, lb_value}, 32'd0);
      // R5: invalid words with loopback code are ignored
      step(1'b0, 1'b1, 32'hFFFA_0000, 1'b0, 12'h0, 1'b0);
      idle(2);
      // sweep programmed values x all type codes (R2 R3 R4 R5 R6 R7)
      for (int v = 0; v < 4; v++) begin
         for (int c = 0; c < 16; c++) begin
            step(1'b0, 1'b0, 32'h0, 1'b1, 12'h5A3 ^ 12'(v * 12'h1B7 + c), 1'b0);
            step(1'b1, 1'b1, {12'hC3C ^ 12'(c * 7), 4'(c), 16'h0F00 | 16'(c)}, 1'b0, 12'h0, 1'b0);
            step(1'b1, 1'b0, 32'hABCA_0000 | 32'(c), 1'b0, 12'h0, 1'b0);
            step(1'b0, 1'b0, 32'h0, 1'b0, 12'h0, 1'b0);
            step(1'b1, 1'b0, 32'h1234_5678 ^ 32'(v), 1'b0, 12'h0, 1'b0);
            step(1'b0, 1'b0, 32'h0, 1'b0, 12'h0, 1'b1);
         end
      end
      idle(3);
      // R8 R9: deferred writes while pending, last wins
      step(1'b1, 1'b1, 32'h000A_1111, 1'b0, 12'h0, 1'b0);
      step(1'b1, 1'b0, 32'h2222_2222, 1'b1, 12'h111, 1'b0);
      step(1'b0, 1'b0, 32'h0, 1'b1, 12'h222, 1'b0);
      idle(2);
      step(1'b0, 1'b0, 32'h0, 1'b0, 12'h0, 1'b1);
      idle(2);
      step(1'b1, 1'b1, 32'hFFFA_3333, 1'b0, 12'h0, 1'b0);
      idle(2);
      step(1'b0, 1'b0, 32'h0, 1'b0, 12'h0, 1'b1);
      // R10: idle write keeps err set, value applied
      step(1'b0, 1'b0, 32'h0, 1'b1, 12'h3C3, 1'b0);
      idle(2);
      // R8: write coinciding with loopback header is deferred
      step(1'b1, 1'b1, 32'h000A_4444, 1'b1, 12'h777, 1'b0);
      idle(2);
      step(1'b0, 1'b0, 32'h0, 1'b0, 12'h0, 1'b1);
      idle(2);
      // R11: write with releasing tx_done applied directly
      step(1'b1, 1'b1, 32'h000A_5555, 1'b0, 12'h0, 1'b0);
      step(1'b0, 1'b0, 32'h0, 1'b1, 12'h888, 1'b0);
      step(1'b0, 1'b0, 32'h0, 1'b1, 12'h999, 1'b1);
      idle(2);
      // R6: tx_done with a new header keeps pending
      step(1'b1, 1'b1, 32'h000A_6666, 1'b0, 12'h0, 1'b0);
      step(1'b1, 1'b1, 32'h000A_7777, 1'b0, 12'h0, 1'b1);
      idle(2);
      step(1'b0, 1'b0, 32'h0, 1'b0, 12'h0, 1'b1);
      idle(3);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule